// File: doc/BRIEF.md
# Trap Vector Register Legalizer

This block owns the machine-level trap vector register. The register holds a
handler base address and a two-bit mode code. Each software write passes
through a legalizer before it is stored. A mode code that is reserved, or
that names a mode the build does not support, is dropped, and the stored
mode stays as it was. The base is then cut down to the byte alignment of
the mode that is actually stored. Each mode has its own alignment exponent.

The same stored value also drives a trap target query. The core presents a
cause code and a flag that marks the trap as an interrupt. In vectored mode,
an interrupt is sent to the base plus four times the cause. Every other trap
is sent to the base itself. Privilege checks, delegation and any supervisor
copy of the register belong to other blocks.

Top module: `tvec_legalizer`

## Requirements
- R1: After a synchronous reset, the base is zero and the mode is the first supported mode: direct (code 0) when direct mode is enabled, otherwise vectored (code 1). With the defaults, the read value is 0.
- R2: A write with mode bits [1:0] = 0, when direct mode is supported, stores mode 0. The base is the written value with bits below DIRECT_ALIGN (default 2, so 4-byte alignment) cleared.
- R3: A write with mode bits [1:0] = 1, when vectored mode is supported, stores mode 1. The base is the written value with bits below VECTORED_ALIGN (default 6, so 64-byte alignment) cleared.
- R4: A write with mode code 2 or 3 is reserved. It leaves the stored mode unchanged, and the base is still updated.
- R5: A write that selects a mode whose support parameter is 0 leaves the stored mode unchanged. The base is still updated.
- R6: The alignment mask comes from the mode stored after the write, not from the written mode bits.
- R7: When trap_is_irq is 1 and the stored mode is vectored, trap_pc equals base + 4 × trap_cause, computed at full XLEN width.
- R8: When trap_is_irq is 0, or the stored mode is direct, trap_pc equals the base.
- R9: A write becomes visible on csr_rd_data one clock edge after it is presented. When csr_wr_en is 0, the register holds and csr_wr_data has no effect.
- R10: csr_rd_data returns the base in bits [XLEN-1:2] and the mode code in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Write strobe for the register |
| csr_wr_data | input | XLEN | Raw value written by software |
| csr_rd_data | output | XLEN | Stored legal value: base and mode |
| trap_cause | input | CAUSE_W | Cause code of the trap being taken |
| trap_is_irq | input | 1 | 1 when the trap is an interrupt |
| trap_pc | output | XLEN | Handler address for the trap |

## Verification
A wrong stored mode or an unmasked base bit shows up on csr_rd_data at the
first negative edge after the write edge. Both ports read the register
directly, so a bad value also shows at once on trap_pc for an interrupt
query. A mode filter that lets through a reserved or unsupported code is
caught by writes that carry such codes with low base bits set. These writes
expose the mode and the mask chosen from it in the same read. A wrong
vectored offset appears the same cycle the cause is applied, because the
target path has no register.

// File: rtl/tvec_pkg.sv
package tvec_pkg;

    localparam int MODE_W     = 2;
    localparam int ALIGN_MIN  = 2;
    localparam int ALIGN_MAX  = 24;
    localparam int VEC_STRIDE = 2;   // log2 of the bytes per vector slot

    typedef enum logic [MODE_W-1:0] {
        TV_DIRECT   = 2'b00,
        TV_VECTORED = 2'b01,
        TV_RSVD_2   = 2'b10,
        TV_RSVD_3   = 2'b11
    } tv_mode_e;

    typedef struct packed {
        logic     accept;
        tv_mode_e mode;
    } tv_mode_pick_t;

    function automatic logic mode_supported(input logic [MODE_W-1:0] code,
                                            input bit dir_en,
                                            input bit vec_en);
        case (code)
            TV_DIRECT:   return dir_en;
            TV_VECTORED: return vec_en;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic int clamp_align(input int a);
        if (a < ALIGN_MIN) return ALIGN_MIN;
        if (a > ALIGN_MAX) return ALIGN_MAX;
        return a;
    endfunction

endpackage

// File: rtl/tvec_mode_sel.sv
module tvec_mode_sel
    import tvec_pkg::*;
#(
    parameter bit DIRECT_EN   = 1'b1,
    parameter bit VECTORED_EN = 1'b1
) (
    input  logic [MODE_W-1:0] req_mode,
    input  tv_mode_e          cur_mode,
    output tv_mode_pick_t     pick
);
    always_comb begin
        pick.accept = mode_supported(req_mode, DIRECT_EN, VECTORED_EN);
        pick.mode   = pick.accept ? tv_mode_e'(req_mode) : cur_mode;
    end
endmodule

// File: rtl/tvec_base_mask.sv
module tvec_base_mask
    import tvec_pkg::*;
#(
    parameter int XLEN           = 64,
    parameter int DIRECT_ALIGN   = 2,
    parameter int VECTORED_ALIGN = 6
) (
    input  logic [XLEN-1:0] raw,
    input  tv_mode_e        mode,
    output logic [XLEN-1:0] aligned
);
    localparam int DA = clamp_align(DIRECT_ALIGN);
    localparam int VA = clamp_align(VECTORED_ALIGN);
    localparam logic [XLEN-1:0] ONES     = {XLEN{1'b1}};
    localparam logic [XLEN-1:0] DIR_MASK = ONES << DA;
    localparam logic [XLEN-1:0] VEC_MASK = ONES << VA;

    logic [XLEN-1:0] mask;

    always_comb begin
        case (mode)
            TV_VECTORED: mask = VEC_MASK;
            default:     mask = DIR_MASK;
        endcase
        aligned = raw & mask;
    end
endmodule

// File: rtl/tvec_target_gen.sv
module tvec_target_gen
    import tvec_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input  logic [XLEN-1:0]    base,
    input  tv_mode_e           mode,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               is_irq,
    output logic [XLEN-1:0]    target
);
    localparam int PAD_W = XLEN - CAUSE_W - VEC_STRIDE;

    logic [XLEN-1:0] offset;
    logic            use_vec;

    always_comb begin
        offset  = {{PAD_W{1'b0}}, cause, {VEC_STRIDE{1'b0}}};
        use_vec = is_irq && (mode == TV_VECTORED);
        target  = use_vec ? (base + offset) : base;
    end
endmodule

// File: rtl/tvec_legalizer.sv
module tvec_legalizer
    import tvec_pkg::*;
#(
    parameter int XLEN           = 64,
    parameter int CAUSE_W        = 6,
    parameter bit DIRECT_EN      = 1'b1,
    parameter bit VECTORED_EN    = 1'b1,
    parameter int DIRECT_ALIGN   = 2,
    parameter int VECTORED_ALIGN = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_wr_en,
    input  logic [XLEN-1:0]    csr_wr_data,
    output logic [XLEN-1:0]    csr_rd_data,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               trap_is_irq,
    output logic [XLEN-1:0]    trap_pc
);
    localparam tv_mode_e RESET_MODE = DIRECT_EN ? TV_DIRECT : TV_VECTORED;
    localparam int DA = clamp_align(DIRECT_ALIGN);
    localparam int VA = clamp_align(VECTORED_ALIGN);
    localparam logic [XLEN-1:0] LOW_DIR = ~({XLEN{1'b1}} << DA);
    localparam logic [XLEN-1:0] LOW_VEC = ~({XLEN{1'b1}} << VA);

    tv_mode_e        mode_q;
    logic [XLEN-1:0] base_q;
    tv_mode_pick_t   pick;
    logic [XLEN-1:0] base_next;

    tvec_mode_sel #(
        .DIRECT_EN   (DIRECT_EN),
        .VECTORED_EN (VECTORED_EN)
    ) u_mode_sel (
        .req_mode (csr_wr_data[MODE_W-1:0]),
        .cur_mode (mode_q),
        .pick     (pick)
    );

    // The mask follows the mode that will be stored, not the raw bits.
    tvec_base_mask #(
        .XLEN           (XLEN),
        .DIRECT_ALIGN   (DIRECT_ALIGN),
        .VECTORED_ALIGN (VECTORED_ALIGN)
    ) u_base_mask (
        .raw     (csr_wr_data),
        .mode    (pick.mode),
        .aligned (base_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RESET_MODE;
            base_q <= '0;
        end else if (csr_wr_en) begin
            mode_q <= pick.mode;
            base_q <= base_next;
        end
    end

    assign csr_rd_data = {base_q[XLEN-1:MODE_W], mode_q};

    tvec_target_gen #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W)
    ) u_target (
        .base   (base_q),
        .mode   (mode_q),
        .cause  (trap_cause),
        .is_irq (trap_is_irq),
        .target (trap_pc)
    );

    // ---------------- assertions ----------------
    logic [XLEN-1:0] rd_base;
    logic [XLEN-1:0] cause_off;
    assign rd_base   = {csr_rd_data[XLEN-1:MODE_W], {MODE_W{1'b0}}};
    assign cause_off = {{(XLEN-CAUSE_W-VEC_STRIDE){1'b0}}, trap_cause, {VEC_STRIDE{1'b0}}};

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (csr_rd_data == {{(XLEN-MODE_W){1'b0}}, RESET_MODE}));

    a_r4_rsvd_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && csr_wr_data[1]) |=> (csr_rd_data[1:0] == $past(csr_rd_data[1:0])));

    a_r5_mode_supported: assert property (@(posedge clk) disable iff (rst)
        mode_supported(csr_rd_data[1:0], DIRECT_EN, VECTORED_EN));

    a_r2_direct_aligned: assert property (@(posedge clk) disable iff (rst)
        (csr_rd_data[1:0] == TV_DIRECT) |-> ((rd_base & LOW_DIR) == '0));

    a_r3_vec_aligned: assert property (@(posedge clk) disable iff (rst)
        (csr_rd_data[1:0] == TV_VECTORED) |-> ((rd_base & LOW_VEC) == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !csr_wr_en |=> $stable(csr_rd_data));

    a_r7_vec_irq: assert property (@(posedge clk) disable iff (rst)
        (trap_is_irq && csr_rd_data[1:0] == TV_VECTORED) |-> (trap_pc == rd_base + cause_off));

    a_r8_exc_base: assert property (@(posedge clk) disable iff (rst)
        (!trap_is_irq || csr_rd_data[1:0] == TV_DIRECT) |-> (trap_pc == rd_base));

endmodule

// File: tb/tvec_legalizer_tb.sv
`timescale 1ns/1ps
module tvec_legalizer_tb_top;

    localparam int XLEN    = 64;
    localparam int CAUSE_W = 6;
    localparam int NVEC    = 8;

    // Walked in order; each row starts from the state the previous row left.
    localparam logic [XLEN-1:0] TBL_WR [NVEC] = '{
        64'h0000_0000_8000_0103,   // reserved 3, keeps direct            R4
        64'h0000_0000_8000_1235,   // vectored, 64-byte mask              R3
        64'h0000_0000_8000_127E,   // reserved 2, keeps vectored mask     R6
        64'h0000_0000_4000_0006,   // reserved 2                          R4
        64'hFFFF_FFFF_FFFF_FFFC,   // direct                              R2
        64'h0000_0000_0000_0047,   // reserved 3, direct mask             R6
        64'h0000_0000_0000_00FD,   // vectored                            R3
        64'h0000_0000_0000_0003    // reserved 3, vectored mask           R6
    };
    localparam logic [XLEN-1:0] TBL_EXP [NVEC] = '{
        64'h0000_0000_8000_0100,
        64'h0000_0000_8000_1201,
        64'h0000_0000_8000_1241,
        64'h0000_0000_4000_0001,
        64'hFFFF_FFFF_FFFF_FFFC,
        64'h0000_0000_0000_0044,
        64'h0000_0000_0000_00C1,
        64'h0000_0000_0000_0001
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic               wr_en = 1'b0;
    logic [XLEN-1:0]    wr_data = '0;
    logic [XLEN-1:0]    rd_data;
    logic [CAUSE_W-1:0] cause = '0;
    logic               irq = 1'b0;
    logic [XLEN-1:0]    tpc;

    logic               nv_wr_en = 1'b0;
    logic [XLEN-1:0]    nv_wr_data = '0;
    logic [XLEN-1:0]    nv_rd_data;
    logic [CAUSE_W-1:0] nv_cause = '0;
    logic               nv_irq = 1'b0;
    logic [XLEN-1:0]    nv_tpc;

    int checks = 0;
    int errors = 0;

    tvec_legalizer #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dut_i (
        .clk(clk), .rst(rst), .csr_wr_en(wr_en), .csr_wr_data(wr_data),
        .csr_rd_data(rd_data), .trap_cause(cause), .trap_is_irq(irq), .trap_pc(tpc)
    );

    tvec_legalizer #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VECTORED_EN(1'b0)) dut_novec_i (
        .clk(clk), .rst(rst), .csr_wr_en(nv_wr_en), .csr_wr_data(nv_wr_data),
        .csr_rd_data(nv_rd_data), .trap_cause(nv_cause), .trap_is_irq(nv_irq), .trap_pc(nv_tpc)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [XLEN-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic nv_wr(input logic [XLEN-1:0] d);
        @(negedge clk);
        nv_wr_en = 1'b1; nv_wr_data = d;
        @(negedge clk);
        nv_wr_en = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset value", rd_data, '0);
        check("R1 reset value, no vectored", nv_rd_data, '0);
        check("R10 reset target", tpc, '0);

        for (int i = 0; i < NVEC; i++) begin
            wr(TBL_WR[i]);
            check("R2/R3/R4/R6 table row", rd_data, TBL_EXP[i]);
        end

        // R9: write visible only after the edge; no effect without wr_en
        @(negedge clk);
        wr_en = 1'b1; wr_data = 64'h55;
        #1;
        check("R9 before edge", rd_data, 64'h1);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 64'h1234;
        #1;
        check("R9 after edge", rd_data, 64'h41);
        repeat (3) @(negedge clk);
        #1;
        check("R9 hold without strobe", rd_data, 64'h41);

        // R7 / R8: trap targets
        wr(64'h1001);
        check("R3 vectored base", rd_data, 64'h1001);
        irq = 1'b1; cause = 6'd5; #1;
        check("R7 irq cause 5", tpc, 64'h1014);
        cause = 6'd63; #1;
        check("R7 irq cause 63", tpc, 64'h10FC);
        cause = 6'd0; #1;
        check("R7 irq cause 0", tpc, 64'h1000);
        irq = 1'b0; cause = 6'd5; #1;
        check("R8 exception in vectored", tpc, 64'h1000);
        wr(64'h2000);
        check("R2 direct base", rd_data, 64'h2000);
        irq = 1'b1; #1;
        check("R8 irq in direct", tpc, 64'h2000);
        irq = 1'b0;
        wr(64'hFFFF_FFFF_FFFF_FFC1);
        irq = 1'b1; cause = 6'd63; #1;
        check("R7 full-width wrap", tpc, 64'h0000_0000_0000_00BC);
        irq = 1'b0;

        // R5: vectored disabled
        nv_wr(64'h2001);
        check("R5 unsupported mode kept", nv_rd_data, 64'h2000);
        nv_irq = 1'b1; nv_cause = 6'd3; #1;
        check("R5 target stays at base", nv_tpc, 64'h2000);
        nv_irq = 1'b0;
        nv_wr(64'h3047);
        check("R6 reserved mode, direct mask", nv_rd_data, 64'h3044);

        finish_run();
    end

endmodule